// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines from peripherals and produces one interrupt request for the processor. Each line passes through a two-flop synchroniser. The synchronised levels form a pending vector that follows the lines directly: nothing is latched, and software never clears a bit. A software-written enable mask selects which pending bits may raise the request. The request is a registered OR of the masked pending bits.

Software reaches the block over a simple word-addressed register bus. The bus has one select strobe, a write flag, an address and write data. Read data and an error flag come back one cycle after the access. One word holds the enable mask. Another gives a read-only view of the pending vector. Two further words take writes and discard them, so existing drivers keep working. Any other access is flagged as an error.

Top module: `intc_level_mask`

## Requirements
- R1: Pending bit i equals input line i as sampled two clock edges earlier. A read of the status word at offset 0x0C returns the pending vector as it stood before the edge that captures the read.
- R2: `cpu_irq` is a register. After each edge it equals the OR of (mask AND pending), using the mask and pending values held before that edge.
- R3: The mask word at offset 0x04 can be read and written. A write takes effect at the capturing edge. A read returns the mask as it stood before that edge.
- R4: The status word at offset 0x0C is read-only. A write to it is a bad access and does not change any state.
- R5: Writes to offsets 0x00 and 0x14 complete without an error. They leave the mask, the pending vector and `cpu_irq` unchanged.
- R6: A bad access raises `bus_err` for exactly one cycle, with `bus_rdata` at zero, and changes no state. Bad accesses are reads of any offset other than 0x04 and 0x0C, and writes to any offset other than 0x00, 0x04 and 0x14.
- R7: While reset is asserted, and right after it is released, the mask and pending vectors are zero and `cpu_irq` and `bus_err` are low.
- R8: Line positions are fixed. Bits 0 to 7 carry the low general-purpose lines, bit 8 the high general-purpose line, bit 22 the keyboard, bit 23 the auxiliary pointer port, and bit 26 the timer match.
- R9: Pending bits are not latched. A bit clears when its input falls, whether it was masked and whether it was ever read.
- R10: `bus_rdata` is zero in every cycle that does not follow a good read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Level-sensitive interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register word |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| bus_err | output | 1 | Bad-access flag, one cycle after the access |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A mask write and a change in the pending vector can land on the same edge. The request for that edge must then combine the old mask with the old pending value. The bench provokes this with a directed step that writes the mask in the cycle in which a line rises. It follows with a long run of random line toggles, interleaved with random reads and writes to good and bad offsets. A behavioural model built on a queue of sampled line values predicts the request, the read data and the error flag, and these are compared at every falling edge.

// File: rtl/intc_lvl_pkg.sv
package intc_lvl_pkg;
   // register word offsets (software-visible)
   localparam logic [31:0] OFS_SINK_A = 32'h00;
   localparam logic [31:0] OFS_MASK   = 32'h04;
   localparam logic [31:0] OFS_STAT   = 32'h0C;
   localparam logic [31:0] OFS_SINK_B = 32'h14;

   // fixed line positions
   localparam int SRC_GPL_BASE = 0;
   localparam int SRC_GPL_NUM  = 8;
   localparam int SRC_GPH      = 8;
   localparam int SRC_KBD      = 22;
   localparam int SRC_AUX      = 23;
   localparam int SRC_TMR0     = 26;

   typedef enum logic [2:0] {
      ACC_IDLE, ACC_MASK_WR, ACC_MASK_RD, ACC_STAT_RD, ACC_SINK_WR, ACC_BAD
   } acc_e;

   function automatic acc_e classify(input logic sel, input logic wr,
                                     input logic [31:0] a);
      if (!sel) return ACC_IDLE;
      if (wr) begin
         if (a == OFS_MASK) return ACC_MASK_WR;
         if (a == OFS_SINK_A || a == OFS_SINK_B) return ACC_SINK_WR;
         return ACC_BAD;
      end
      if (a == OFS_MASK) return ACC_MASK_RD;
      if (a == OFS_STAT) return ACC_STAT_RD;
      return ACC_BAD;
   endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_lvl_pkg::*;
#(
   parameter int N_IRQ = 32,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   input  logic [N_IRQ-1:0] pend,
   output logic [N_IRQ-1:0] mask,
   output logic [DW-1:0]    rdata,
   output logic             err
);
   acc_e acc;
   always_comb acc = classify(bus_sel, bus_wr, 32'(bus_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask  <= '0;
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err   <= (acc == ACC_BAD);
         rdata <= '0;
         case (acc)
            ACC_MASK_WR: mask  <= bus_wdata[N_IRQ-1:0];
            ACC_MASK_RD: rdata <= DW'(mask);
            ACC_STAT_RD: rdata <= DW'(pend);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/intc_req.sv
module intc_req #(
   parameter int N_IRQ = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] mask,
   input  logic [N_IRQ-1:0] pend,
   output logic             req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= |(mask & pend);
   end
endmodule

// File: rtl/intc_level_mask.sv
module intc_level_mask #(
   parameter int N_IRQ       = 32,
   parameter int AW          = 8,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic             bus_err,
   output logic             cpu_irq
);
   localparam int MIN_AW = 5;

   generate
      if (N_IRQ < 1 || N_IRQ > 32) begin : g_bad_n
         $error("N_IRQ must lie in 1..32");
      end
      if (DW < N_IRQ) begin : g_bad_dw
         $error("DW must be at least N_IRQ");
      end
      if (AW < MIN_AW || AW > 32) begin : g_bad_aw
         $error("AW must lie in 5..32");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic [N_IRQ-1:0] pend_w;
   logic [N_IRQ-1:0] mask_w;

   intc_sync #(.W(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(pend_w)
   );

   intc_regs #(.N_IRQ(N_IRQ), .AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend(pend_w),
      .mask(mask_w), .rdata(bus_rdata), .err(bus_err)
   );

   intc_req #(.N_IRQ(N_IRQ)) u_req (
      .clk(clk), .rst_n(rst_n), .mask(mask_w), .pend(pend_w), .req(cpu_irq)
   );
endmodule

// File: rtl/intc_level_mask_chk.sv
module intc_level_mask_chk
   import intc_lvl_pkg::*;
#(
   parameter int N_IRQ       = 32,
   parameter int AW          = 8,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_IRQ-1:0] irq_in,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_rdata,
   input logic             bus_err,
   input logic             cpu_irq,
   input logic [N_IRQ-1:0] mask_q,
   input logic [N_IRQ-1:0] pend_q
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   logic mask_wr_hit;
   assign mask_wr_hit = bus_sel && bus_wr && (32'(bus_addr) == OFS_MASK);

   // R2: registered request tracks masked pending of the previous cycle
   assert_req_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0) |-> (cpu_irq == $past(|(mask_q & pend_q))));

   // R6: error only in the cycle after an access
   assert_err_needs_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> !bus_err);

   // R6: error reads as zero data
   assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0));

   // R3, R5: mask moves only on a write to its own word
   assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr_hit |=> $stable(mask_q));

   // R10: no data after an idle cycle
   assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> (bus_rdata == '0));

   // R7: held clear in reset
   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |-> (!cpu_irq && !bus_err && mask_q == '0 && pend_q == '0));

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         // R1, R9: pending follows the line two edges later
         assert_pend_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (pend_q == $past(irq_in, 2)));
      end
   endgenerate
endmodule

bind intc_level_mask intc_level_mask_chk #(
   .N_IRQ(N_IRQ), .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .bus_err(bus_err), .cpu_irq(cpu_irq), .mask_q(mask_w), .pend_q(pend_w)
);

// File: tb/tb_intc_level_mask.sv
module tb_intc_level_mask;
   import intc_lvl_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] irq = '0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        err, cpu_irq;

   int vectors = 0;
   int miscompares = 0;

   always #2 clk = ~clk;

   intc_level_mask dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_sel(sel), .bus_wr(wr),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
      .cpu_irq(cpu_irq)
   );

   // behavioural reference: queue of sampled line values
   logic [31:0] hist[$];
   logic [31:0] m_mask;
   logic        exp_req, exp_err;
   logic [31:0] exp_rd;

   always @(posedge clk or negedge rst_n) begin : model
      logic [31:0] p_old;
      if (!rst_n) begin
         hist = '{32'h0, 32'h0, 32'h0};
         m_mask = '0; exp_req = 0; exp_err = 0; exp_rd = '0;
      end else begin
         hist.push_front(irq);
         p_old = hist[2];
         void'(hist.pop_back());
         exp_req = |(m_mask & p_old);
         exp_err = 0;
         exp_rd  = '0;
         if (sel) begin
            if (wr) begin
               if (addr == 8'h04) m_mask = wdata;
               else if (!(addr == 8'h00 || addr == 8'h14)) exp_err = 1;
            end else begin
               if (addr == 8'h04)      exp_rd = m_mask;
               else if (addr == 8'h0C) exp_rd = p_old;
               else                    exp_err = 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         chk("R2 cpu_irq", {31'b0, cpu_irq}, {31'b0, exp_req});
         chk("R6 bus_err", {31'b0, err}, {31'b0, exp_err});
         chk("R3 R4 R10 bus_rdata", rdata, exp_rd);
      end
   end

   task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic e);
      @(negedge clk); #0.5;
      sel = 1; wr = w; addr = a; wdata = d;
      @(negedge clk); #0.5;
      sel = 0; wr = 0;
      rd = rdata; e = err;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #0.5;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : stim
      logic [31:0] r;
      logic e;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R7 cpu_irq in reset", {31'b0, cpu_irq}, 32'h0);
      chk("R7 bus_err in reset", {31'b0, err}, 32'h0);
      #0.5 rst_n = 1;
      access(0, 8'h04, 0, r, e); chk("R7 mask after reset", r, 32'h0);
      access(0, 8'h0C, 0, r, e); chk("R7 status after reset", r, 32'h0);

      // R1: pending follows lines
      irq = 32'h0000_00A5; idle(3);
      access(0, 8'h0C, 0, r, e); chk("R1 status mirrors lines", r, 32'h0000_00A5);
      // R9: clears when the line falls, though never unmasked
      irq = 32'h0000_0080; idle(3);
      access(0, 8'h0C, 0, r, e); chk("R9 status clears on fall", r, 32'h0000_0080);
      irq = 0; idle(3);
      access(0, 8'h0C, 0, r, e); chk("R9 status all clear", r, 32'h0);

      // R3: mask read/write
      access(1, 8'h04, 32'h0000_00F0, r, e); chk("R3 mask write no err", {31'b0, e}, 32'h0);
      access(0, 8'h04, 0, r, e); chk("R3 mask readback", r, 32'h0000_00F0);
      // R2: enabled line raises the request, masked one does not
      irq = 32'h0000_0010; idle(4);
      chk("R2 enabled line requests", {31'b0, cpu_irq}, 32'h1);
      irq = 32'h0000_0001; idle(4);
      chk("R2 masked line silent", {31'b0, cpu_irq}, 32'h0);

      // R5: sink writes
      access(1, 8'h00, 32'hFFFF_FFFF, r, e); chk("R5 write 0x00 no err", {31'b0, e}, 32'h0);
      access(1, 8'h14, 32'hFFFF_FFFF, r, e); chk("R5 write 0x14 no err", {31'b0, e}, 32'h0);
      access(0, 8'h04, 0, r, e); chk("R5 mask untouched", r, 32'h0000_00F0);
      chk("R5 request unchanged", {31'b0, cpu_irq}, 32'h0);

      // R4 / R6: bad accesses
      access(1, 8'h0C, 32'hFFFF_FFFF, r, e); chk("R4 write to status flagged", {31'b0, e}, 32'h1);
      access(0, 8'h00, 0, r, e); chk("R6 read 0x00 flagged", {31'b0, e}, 32'h1);
      chk("R6 read 0x00 data zero", r, 32'h0);
      access(0, 8'h14, 0, r, e); chk("R6 read 0x14 flagged", {31'b0, e}, 32'h1);
      access(1, 8'h08, 32'hFFFF_FFFF, r, e); chk("R6 write 0x08 flagged", {31'b0, e}, 32'h1);
      idle(1); chk("R6 error lasts one cycle", {31'b0, err}, 32'h0);
      access(0, 8'h04, 0, r, e); chk("R6 mask survives bad writes", r, 32'h0000_00F0);

      // R8: timer and keyboard positions
      access(1, 8'h04, 32'h1 << SRC_TMR0, r, e);
      irq = (32'h1 << SRC_TMR0) | (32'h1 << SRC_KBD); idle(4);
      access(0, 8'h0C, 0, r, e); chk("R8 timer bit 26 keyboard bit 22", r, 32'h0440_0000);
      chk("R8 timer line requests", {31'b0, cpu_irq}, 32'h1);
      irq = 32'h1 << SRC_KBD; idle(4);
      chk("R8 keyboard alone masked", {31'b0, cpu_irq}, 32'h0);

      // R2: mask write lands on the edge where a line rises
      irq = 0; access(1, 8'h04, 0, r, e); idle(3);
      @(negedge clk); #0.5;
      sel = 1; wr = 1; addr = 8'h04; wdata = 32'h0000_0100; irq = 32'h0000_0100;
      @(negedge clk); #0.5; sel = 0; wr = 0;
      chk("R2 same-edge request still low", {31'b0, cpu_irq}, 32'h0);
      idle(3);
      chk("R2 request after sync", {31'b0, cpu_irq}, 32'h1);

      // random mix, judged by the every-cycle model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk); #0.5;
         if ($urandom_range(0, 3) == 0) irq = irq ^ (32'h1 << $urandom_range(0, 31));
         sel = ($urandom_range(0, 2) == 0);
         wr  = $urandom_range(0, 1);
         case ($urandom_range(0, 7))
            0: addr = 8'h00; 1, 2: addr = 8'h04; 3, 4: addr = 8'h0C;
            5: addr = 8'h14; 6: addr = 8'h10; default: addr = 8'($urandom_range(0, 255));
         endcase
         wdata = $urandom;
      end
      @(negedge clk); #0.5; sel = 0;
      idle(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule